// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit Slip

This block turns a one-bit serial stream into parallel words. It runs on the bit clock. It takes one bit per rising edge in single-rate mode, or one bit on each clock edge in double-rate mode. A word is complete after the chosen number of bits. The block then loads the word into `word_out` and raises `word_valid` for one cycle. The word-rate clock of a receiver appears here as this valid strobe, so downstream logic can run at the slower rate on a clock enable.

The history register is made of fixed-size stages of six bits. The newest stage feeds the older stage, so words of up to ten bits are taken from across the join between them.

A training controller outside the block compares the received words with a known pattern. When they differ, it pulses `slip`. Each pulse moves the word boundary one bit later in the stream. Mode and width are static while the block runs and change only under reset. If the width request is not legal for the selected mode, the block flags it and uses a corrected width.

Top module: `serial_to_parallel`

## Requirements
- R1: In single-rate mode (`ddr_mode`=0), one bit is taken per rising clock edge. The legal widths are 2 to 8. A word holds that many consecutive stream bits, and bit 0 of `word_out` is the bit received first.
- R2: In double-rate mode (`ddr_mode`=1), each clock cycle adds two stream bits: the bit sampled at the rising edge, then the bit sampled at the following falling edge. The legal widths are 4, 6, 8 and 10. The bit order in the word is the same as in R1.
- R3: Without slips, successive valid words cover back-to-back, non-overlapping runs of the stream. The first word after reset starts with the bit sampled at the first rising edge at which `rst` is low.
- R4: `width_err` is 1 exactly when `width_req` is illegal for the mode. `width_eff` gives the width in use. The rules are:
  - a legal request is used unchanged;
  - an illegal request falls back to the largest legal width below it;
  - a request below the smallest legal width (2 in single-rate, 4 in double-rate) uses that smallest width.
- R5: When `word_valid` is 1, all bits of `word_out` at or above `width_eff` are 0.
- R6: A one-cycle pulse on `slip` moves the word boundary one bit later. Let S be the start of the first word not yet loaded when the pulse is sampled (counting a word loaded at that same edge). The first valid word after the pulse then starts at bit S + 2·W + 1.
- R7: The two word loads after a slip pulse, including one at the same edge, have `word_valid` low. `word_valid` is always low in the cycle after an edge that sampled `slip` high.
- R8: After W slips, where W is the word width, words again start at the same stream positions modulo W as before the slips.
- R9: While `rst` is high, `word_valid` and `word_out` are 0 after the next rising edge.
- R10: Words wider than one six-bit stage (widths 8 and 10) are assembled correctly across the join between the chained stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the rising edge is used in both modes, the falling edge as well in double-rate |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 1 | Serial data input |
| ddr_mode | input | 1 | 0 = single-rate capture, 1 = double-rate capture |
| width_req | input | 4 | Requested word width in bits |
| slip | input | 1 | One-cycle request to move the word boundary by one bit |
| word_out | output | 10 | Parallel word, first-received bit at bit 0 |
| word_valid | output | 1 | One-cycle strobe marking a new valid word |
| width_eff | output | 4 | Word width actually in use |
| width_err | output | 1 | Requested width is illegal for the selected mode |

## Verification
A slip request and a word load can land on the same bit-clock edge. When they do, the block must either defer the load (single-rate, or double-rate at offset 0) or let it through with its valid strobe suppressed (double-rate at offset 1). The bench provokes this on purpose. It waits for a valid word and counts W/k − 1 further cycles, where k is the number of bits per cycle. It then pulses `slip` so that the pulse is sampled at exactly the next load edge. It does this twice in a row in double-rate mode, so that both offset states are hit. The result is judged by the stream model: the next valid word must start at S + 2·W + 1, and no valid strobe may appear between the slip and that word.

// File: rtl/desr_pkg.sv
package desr_pkg;

  typedef enum logic {
    LANE_SDR = 1'b0,
    LANE_DDR = 1'b1
  } lane_mode_e;

  // Legality of a requested width for a lane mode.
  function automatic logic width_ok(input lane_mode_e mode, input int unsigned req,
                                    input int unsigned lo_s, input int unsigned hi_s,
                                    input int unsigned lo_d, input int unsigned hi_d);
    if (mode == LANE_SDR) return (req >= lo_s) && (req <= hi_s);
    return (req >= lo_d) && (req <= hi_d) && (((req - lo_d) & 1) == 0);
  endfunction

  // Width actually used: clamp into range, then drop to an even step in DDR.
  function automatic int unsigned width_fit(input lane_mode_e mode, input int unsigned req,
                                            input int unsigned lo_s, input int unsigned hi_s,
                                            input int unsigned lo_d, input int unsigned hi_d);
    int unsigned r;
    if (mode == LANE_SDR) begin
      if (req < lo_s) r = lo_s;
      else if (req > hi_s) r = hi_s;
      else r = req;
    end else begin
      if (req < lo_d) r = lo_d;
      else if (req > hi_d) r = hi_d;
      else r = req - ((req - lo_d) & 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/desr_capture.sv
module desr_capture (
  input  logic       clk,
  input  logic       rst,
  input  logic       sdin,
  output logic [1:0] pair,
  output logic       primed
);
  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      primed <= 1'b0;
    end else begin
      rise_q <= sdin;
      primed <= 1'b1;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= sdin;
  end

  // Earlier (rising) bit in the low position.
  assign pair = {fall_q, rise_q};
endmodule

// File: rtl/desr_stage.sv
module desr_stage #(
  parameter int STAGE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               ddr,
  input  logic [1:0]         din,
  output logic [STAGE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      if (ddr) q <= {din, q[STAGE_W-1:2]};
      else     q <= {din[0], q[STAGE_W-1:1]};
    end
  end
endmodule

// File: rtl/desr_widthsel.sv
module desr_widthsel
  import desr_pkg::*;
#(
  parameter int WW     = 4,
  parameter int SDR_LO = 2,
  parameter int SDR_HI = 8,
  parameter int DDR_LO = 4,
  parameter int DDR_HI = 10
) (
  input  logic          ddr,
  input  logic [WW-1:0] req,
  output logic [WW-1:0] eff,
  output logic          err
);
  lane_mode_e mode;
  assign mode = lane_mode_e'(ddr);

  always_comb begin
    eff = WW'(width_fit(mode, int'(req), SDR_LO, SDR_HI, DDR_LO, DDR_HI));
    err = !width_ok(mode, int'(req), SDR_LO, SDR_HI, DDR_LO, DDR_HI);
  end
endmodule

// File: rtl/desr_framer.sv
module desr_framer #(
  parameter int MAXW = 10,
  parameter int HIST = 12,
  parameter int WW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            primed,
  input  logic            ddr,
  input  logic            slip,
  input  logic [1:0]      pair,
  input  logic [HIST-1:0] hist,
  input  logic [WW-1:0]   width,
  output logic [MAXW-1:0] word_out,
  output logic            word_valid,
  output logic            emit,
  output logic [1:0]      sup_cnt
);
  localparam int CW = WW + 1;
  localparam int EW = HIST + 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_sum;
  logic          off_q;
  logic          hold;
  logic          slip_seen;
  logic [EW-1:0] ext;

  // Word taken from the history plus the bits arriving this cycle.
  function automatic logic [MAXW-1:0] pick(input logic [EW-1:0] v, input logic d,
                                           input logic o, input int w);
    logic [EW-1:0] s;
    logic [EW-1:0] m;
    int top;
    top = (d ? EW - 1 : EW - 2) - int'(o);
    s   = v >> (top - w + 1);
    m   = (EW'(1) << w) - EW'(1);
    return MAXW'(s & m);
  endfunction

  assign ext       = {pair, hist};
  assign cnt_sum   = cnt_q + (ddr ? CW'(2) : CW'(1));
  assign slip_seen = primed && slip;
  // A slip delays counting unless a DDR half-step offset can absorb it.
  assign hold      = slip_seen && (!ddr || !off_q);
  assign emit      = primed && !hold && (cnt_sum >= CW'(width));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      off_q      <= 1'b0;
      sup_cnt    <= 2'd0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= emit && (sup_cnt == 2'd0) && !slip_seen;
      if (emit) word_out <= pick(ext, ddr, off_q, int'(width));

      if (!primed)   cnt_q <= '0;
      else if (emit) cnt_q <= '0;
      else if (!hold) cnt_q <= cnt_sum;

      if (slip_seen && ddr) off_q <= ~off_q;

      if (slip_seen)                      sup_cnt <= emit ? 2'd1 : 2'd2;
      else if (emit && sup_cnt != 2'd0)   sup_cnt <= sup_cnt - 2'd1;
    end
  end
endmodule

// File: rtl/serial_to_parallel.sv
module serial_to_parallel #(
  parameter int STAGE_W = 6,
  parameter int SDR_LO  = 2,
  parameter int SDR_HI  = 8,
  parameter int DDR_LO  = 4,
  parameter int DDR_HI  = 10,
  parameter int MAXW    = (SDR_HI > DDR_HI) ? SDR_HI : DDR_HI,
  parameter int WW      = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sdin,
  input  logic            ddr_mode,
  input  logic [WW-1:0]   width_req,
  input  logic            slip,
  output logic [MAXW-1:0] word_out,
  output logic            word_valid,
  output logic [WW-1:0]   width_eff,
  output logic            width_err
);
  localparam int WIN  = MAXW + 1;
  localparam int NSTG = (WIN + STAGE_W - 1) / STAGE_W;
  localparam int HIST = NSTG * STAGE_W;

  logic [1:0]         pair;
  logic               primed;
  logic [1:0]         lnk [NSTG];
  logic [STAGE_W-1:0] stq [NSTG];
  logic [HIST-1:0]    hist;
  logic               emit;
  logic [1:0]         sup_cnt;

  desr_capture u_cap (
    .clk    (clk),
    .rst    (rst),
    .sdin   (sdin),
    .pair   (pair),
    .primed (primed)
  );

  // Stage 0 is the master (newest bits); each later stage takes the
  // bits shifted out of the stage before it.
  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign lnk[g] = pair;
    end else begin : g_tail
      assign lnk[g] = ddr_mode ? stq[g-1][1:0] : {1'b0, stq[g-1][0]};
    end
    desr_stage #(.STAGE_W(STAGE_W)) u_stg (
      .clk (clk),
      .rst (rst),
      .en  (primed),
      .ddr (ddr_mode),
      .din (lnk[g]),
      .q   (stq[g])
    );
    assign hist[HIST-1-g*STAGE_W -: STAGE_W] = stq[g];
  end

  desr_widthsel #(
    .WW(WW), .SDR_LO(SDR_LO), .SDR_HI(SDR_HI), .DDR_LO(DDR_LO), .DDR_HI(DDR_HI)
  ) u_wsel (
    .ddr (ddr_mode),
    .req (width_req),
    .eff (width_eff),
    .err (width_err)
  );

  desr_framer #(.MAXW(MAXW), .HIST(HIST), .WW(WW)) u_frm (
    .clk        (clk),
    .rst        (rst),
    .primed     (primed),
    .ddr        (ddr_mode),
    .slip       (slip),
    .pair       (pair),
    .hist       (hist),
    .width      (width_eff),
    .word_out   (word_out),
    .word_valid (word_valid),
    .emit       (emit),
    .sup_cnt    (sup_cnt)
  );
endmodule

// File: rtl/serial_to_parallel_chk.sv
module serial_to_parallel_chk #(
  parameter int MAXW = 10,
  parameter int WW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            slip,
  input logic            ddr_mode,
  input logic [WW-1:0]   width_req,
  input logic [WW-1:0]   width_eff,
  input logic            width_err,
  input logic [MAXW-1:0] word_out,
  input logic            word_valid,
  input logic            emit,
  input logic [1:0]      sup_cnt
);
  AST_SLIP_MUTES_NEXT: assert property (@(posedge clk) disable iff (rst)
    slip |=> !word_valid); // R7
  AST_SUPPRESS_BOUND: assert property (@(posedge clk) disable iff (rst)
    sup_cnt <= 2'd2); // R7
  AST_VALID_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(emit)); // R3
  AST_UPPER_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ((word_out >> width_eff) == '0)); // R5
  AST_FLAG_MEANS_CHANGED: assert property (@(posedge clk) disable iff (rst)
    width_err |-> (width_eff != width_req)); // R4
  AST_DDR_WIDTH_EVEN: assert property (@(posedge clk) disable iff (rst)
    ddr_mode |-> !width_eff[0]); // R2
endmodule

bind serial_to_parallel serial_to_parallel_chk #(.MAXW(MAXW), .WW(WW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slip       (slip),
  .ddr_mode   (ddr_mode),
  .width_req  (width_req),
  .width_eff  (width_eff),
  .width_err  (width_err),
  .word_out   (word_out),
  .word_valid (word_valid),
  .emit       (emit),
  .sup_cnt    (sup_cnt)
);

// File: tb/tb_serial_to_parallel.sv
module tb_serial_to_parallel;
  localparam int CLK_PERIOD = 8;
  localparam int QTR  = CLK_PERIOD / 4;
  localparam int MAXW = 10;
  localparam int WW   = 4;
  localparam int RING = 4096;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sdin = 1'b0;
  logic            ddr_mode = 1'b0;
  logic [WW-1:0]   width_req = 4'd4;
  logic            slip = 1'b0;
  logic [MAXW-1:0] word_out;
  logic            word_valid;
  logic [WW-1:0]   width_eff;
  logic            width_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_to_parallel dut (
    .clk(clk), .rst(rst), .sdin(sdin), .ddr_mode(ddr_mode), .width_req(width_req),
    .slip(slip), .word_out(word_out), .word_valid(word_valid),
    .width_eff(width_eff), .width_err(width_err)
  );

  int   checks = 0;
  int   fails  = 0;
  logic bits [RING];
  int   nb = 0;
  int   p = 0;
  int   nvalid = 0;
  int   wcur = 4;
  int   nslip = 0;
  int   cfg_words = 0;
  bit   started = 0;
  bit   done = 0;

  function automatic bit is_legal(bit d, int c);
    if (d) return (c == 4) || (c == 6) || (c == 8) || (c == 10);
    return (c >= 2) && (c <= 8);
  endfunction

  function automatic int exp_eff(bit d, int req);
    for (int c = req; c >= 0; c--) if (is_legal(d, c)) return c;
    return d ? 4 : 2;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Stimulus: rise bit set before each rising edge, fall bit before each falling edge.
  initial begin
    forever begin
      @(negedge clk); #QTR;
      sdin = 1'($urandom_range(1, 0));
      @(posedge clk); #QTR;
      if (ddr_mode) sdin = 1'($urandom_range(1, 0));
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      started = 0;
      nb = 0;
    end else begin
      bits[nb % RING] = sdin;
      nb++;
      started = 1;
    end
  end

  always @(negedge clk) begin
    logic [MAXW-1:0] exp_w;
    string tag;
    if (!rst && started && ddr_mode) begin
      bits[nb % RING] = sdin;
      nb++;
    end
    if (!rst && word_valid) begin
      exp_w = '0;
      for (int j = 0; j < wcur; j++) exp_w[j] = bits[(p + j) % RING];
      if (nslip >= wcur)      tag = "R8 word after W slips";
      else if (nslip > 0)     tag = "R6 word after slip";
      else if (cfg_words < 2) tag = "R3 first words";
      else if (wcur > 6)      tag = "R10 cascaded word";
      else if (ddr_mode)      tag = "R2 ddr word";
      else                    tag = "R1 sdr word";
      check(word_out == exp_w, tag, word_out, exp_w);
      p += wcur;
      nvalid++;
      cfg_words++;
    end
  end

  task automatic wait_words(int n);
    int v0;
    v0 = nvalid;
    wait (nvalid >= v0 + n);
  endtask

  // Called at a falling-edge time; the pulse is sampled at the next rising edge.
  task automatic slip_now();
    int v0;
    #QTR;
    p = p + 2 * wcur + 1;
    slip = 1'b1;
    nslip++;
    @(negedge clk);
    check(word_valid == 1'b0, "R7 valid after slip edge", word_valid, 0);
    #QTR;
    slip = 1'b0;
    v0 = nvalid;
    wait (nvalid != v0);
  endtask

  task automatic run_cfg(bit d, int req);
    int k;
    k = d ? 2 : 1;
    rst = 1'b1;
    ddr_mode = d;
    width_req = WW'(req);
    repeat (3) @(negedge clk);
    check(word_valid == 1'b0, "R9 valid in reset", word_valid, 0);
    check(word_out == '0, "R9 word in reset", word_out, 0);
    wcur = exp_eff(d, req);
    check(width_eff == WW'(wcur), "R4 effective width", width_eff, wcur);
    check(width_err == (wcur != req), "R4 width flag", width_err, (wcur != req));
    p = 0;
    nslip = 0;
    cfg_words = 0;
    #QTR rst = 1'b0;
    wait_words(6);
    // Slips that land on the same edge as a word load (twice: both DDR offsets).
    for (int c = 0; c < 2; c++) begin
      wait_words(1);
      repeat (wcur / k - 1) @(negedge clk);
      slip_now();
      wait_words(2);
    end
    for (int s = 0; s < wcur + 1; s++) begin
      repeat ($urandom_range(7, 0)) @(negedge clk);
      slip_now();
    end
    wait_words(5);
  endtask

  initial begin
    void'($urandom(32'h5eed_0713));
    run_cfg(0, 2);
    run_cfg(0, 5);
    run_cfg(0, 8);
    run_cfg(0, 1);
    run_cfg(0, 11);
    run_cfg(1, 4);
    run_cfg(1, 6);
    run_cfg(1, 10);
    run_cfg(1, 7);
    run_cfg(1, 3);
    run_cfg(1, 14);
    run_cfg(1, 9);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule